// File: doc/BRIEF.md
# Two-Lane Double to Int32 Truncating Converter

This block accepts a 128-bit operand that holds two double-precision floating-point values. It converts each value to a signed 32-bit integer and always rounds toward zero. The two integers are packed into a 64-bit result. The block also drives a 128-bit wide destination that carries the same 64 bits in its lower half and zeros in its upper half. Both lanes share one invalid flag and one precision flag.

A lane is invalid when its value cannot be represented as a 32-bit integer: NaN, infinity, or a value outside the int32 range. When the invalid condition is masked, an invalid lane returns the integer-indefinite pattern. When the condition is unmasked and either lane is invalid, an exception strobe is raised instead, and the destination keeps its previous contents. Each operation is presented for one cycle on `inValid`, and its results appear one clock later.

Top module: `dcvt_trunc2`

## Requirements
- R1: Source bits [63:0] (lane 0) convert into result bits [31:0], and source bits [127:64] (lane 1) convert into result bits [63:32]. `narrowDst` carries exactly these 64 bits.
- R2: `wideDst[127:64]` is always zero, and `wideDst[63:0]` always equals `narrowDst`.
- R3: An in-range finite value converts to its integer part, truncated toward zero, for both signs. Example: 2147483647.9 gives 7FFF_FFFFh.
- R4: A lane whose biased exponent field (bits 62:52 of the lane) is all ones, or whose value is at least 2^31, or whose value is at most -2^31-1, is invalid. With `invMask`=1 that lane's result is 8000_0000h. `flagInvalid` is the OR over both lanes.
- R5: `flagPrecision` is the OR over the valid lanes of "result differs from the source value". An invalid lane never contributes to it.
- R6: Values in the range (-2^31-1, -2^31] give 8000_0000h as a valid result. They raise precision only when the value is not exactly -2^31.
- R7: Zeros of either sign, denormals and any value with magnitude below 1 give 0. Precision is raised exactly when the value is nonzero.
- R8: With `invMask`=0 and at least one invalid lane, `excRaise` is 1 in the result cycle and neither lane of the destination changes. Both flags are still reported.
- R9: Results, flags and `outValid` appear on the clock edge after the one at which `inValid`=1 is sampled. In cycles with no operation, `outValid` and `excRaise` are 0, and the destination and flags hold their values.
- R10: After reset, the destination and both flags are zero, and `outValid` and `excRaise` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| invMask | input | 1 | 1: invalid lanes return the indefinite value; 0: invalid raises an exception |
| srcData | input | 128 | Two double-precision lanes |
| outValid | output | 1 | Results of the previous operation are valid |
| excRaise | output | 1 | Unmasked invalid exception for the previous operation |
| flagInvalid | output | 1 | Invalid condition seen in either lane |
| flagPrecision | output | 1 | Inexact result in a valid lane |
| wideDst | output | 128 | Wide destination: results in bits 63:0, zeros above |
| narrowDst | output | 64 | Narrow destination: the two 32-bit results |

## Verification
The hardest cases to reach are at the edge of the int32 range. One is the narrow band just below -2^31, where truncation still gives a valid result. Another is an operand pair in which one lane is invalid and the other is inexact, so that the shared flags must separate the two contributions. The sweep covers every biased exponent from the bias up to the bias plus 33 and pairs each with mantissa patterns near the integer boundary. It gives the two lanes opposite signs and different exponents, and it alternates the invalid mask. Directed values pin the exact boundaries, the NaN kinds, and the destination hold under an unmasked exception.

// File: rtl/dcvt_pkg.sv
package dcvt_pkg;
  // Strobes from control to datapath for one operation.
  typedef struct packed {
    logic wrDst;     // commit lane results to the destination
    logic updFlags;  // capture the merged flag pair
    logic raiseExc;  // unmasked invalid: signal instead of writing
  } ctrlStrb_t;
endpackage

// File: rtl/dcvt_lane.sv
module dcvt_lane #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32
) (
  input  logic [EXP_W+MAN_W:0] fpIn,
  output logic [INT_W-1:0]     intOut,
  output logic                 invalid,
  output logic                 inexact
);
  localparam int FP_W  = EXP_W + MAN_W + 1;
  localparam int SIG_W = MAN_W + 1;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int MAXE  = BIAS + INT_W - 1;
  localparam int SH_W  = $clog2(SIG_W + 1);

  logic             sgn, special, tiny, huge, lost, overRange, tinyNz;
  logic [EXP_W-1:0] expF;
  logic [MAN_W-1:0] manF;
  logic [SIG_W-1:0] sig, intPart, lostMask, limit;
  logic [SH_W-1:0]  sh;

  always_comb begin
    sgn     = fpIn[FP_W-1];
    expF    = fpIn[FP_W-2:MAN_W];
    manF    = fpIn[MAN_W-1:0];
    special = &expF;
    tiny    = expF < EXP_W'(BIAS);
    huge    = !special && (expF > EXP_W'(MAXE));
    tinyNz  = (expF != '0) || (manF != '0);
    sig     = {1'b1, manF};
    sh      = SH_W'(MAN_W);
    if (!tiny && !huge && !special) sh = SH_W'(MAN_W + BIAS - int'(expF));
    intPart  = sig >> sh;
    lostMask = ~({SIG_W{1'b1}} << sh);
    lost     = |(sig & lostMask);
    // largest magnitude allowed: 2^(INT_W-1)-1 positive, 2^(INT_W-1) negative
    limit     = SIG_W'({1'b0, sgn, {(INT_W-1){~sgn}}});
    overRange = intPart > limit;
    invalid   = special | huge | (!tiny & overRange);
    inexact   = !invalid & (tiny ? tinyNz : lost);
    if (invalid)   intOut = {1'b1, {(INT_W-1){1'b0}}};
    else if (tiny) intOut = '0;
    else           intOut = sgn ? -intPart[INT_W-1:0] : intPart[INT_W-1:0];
  end
endmodule

// File: rtl/dcvt_dp.sv
module dcvt_dp import dcvt_pkg::*; #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32,
  parameter int LANES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [LANES*(EXP_W+MAN_W+1)-1:0] srcData,
  input  ctrlStrb_t                    strb,
  output logic                         anyInv,
  output logic [LANES*INT_W-1:0]       dstReg,
  output logic                         flagInv,
  output logic                         flagPrec
);
  localparam int FP_W = EXP_W + MAN_W + 1;
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  logic [LANES*INT_W-1:0] laneRes;
  logic [LANES-1:0]       laneInv, lanePrec;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    dcvt_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) uLane (
      .fpIn   (srcData[g*FP_W +: FP_W]),
      .intOut (laneRes[g*INT_W +: INT_W]),
      .invalid(laneInv[g]),
      .inexact(lanePrec[g])
    );

    AST_INDEF_MASKED: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrDst && laneInv[g]) |=> (dstReg[g*INT_W +: INT_W] == INDEF)); // R4
  end

  assign anyInv = |laneInv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstReg   <= '0;
      flagInv  <= 1'b0;
      flagPrec <= 1'b0;
    end else begin
      if (strb.wrDst) dstReg <= laneRes;
      if (strb.updFlags) begin
        flagInv  <= anyInv;
        flagPrec <= |lanePrec;
      end
    end
  end

  AST_ALL_INV_NO_PREC: assert property (@(posedge clk) disable iff (!rstN)
    (strb.updFlags && (&laneInv)) |=> (flagInv && !flagPrec)); // R5
endmodule

// File: rtl/dcvt_ctrl.sv
module dcvt_ctrl import dcvt_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      invMask,
  input  logic      anyInv,
  output ctrlStrb_t strb,
  output logic      outValid,
  output logic      excOut
);
  always_comb begin
    strb.raiseExc = inValid & anyInv & ~invMask;
    strb.wrDst    = inValid & ~strb.raiseExc;
    strb.updFlags = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      excOut   <= 1'b0;
    end else begin
      outValid <= inValid;
      excOut   <= strb.raiseExc;
    end
  end

  AST_EXC_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !invMask && anyInv) |=> excOut); // R8
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !excOut)); // R9
endmodule

// File: rtl/dcvt_trunc2.sv
module dcvt_trunc2 import dcvt_pkg::*; #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32,
  parameter int LANES = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 inValid,
  input  logic                                 invMask,
  input  logic [LANES*(EXP_W+MAN_W+1)-1:0]     srcData,
  output logic                                 outValid,
  output logic                                 excRaise,
  output logic                                 flagInvalid,
  output logic                                 flagPrecision,
  output logic [LANES*(EXP_W+MAN_W+1)-1:0]     wideDst,
  output logic [LANES*INT_W-1:0]               narrowDst
);
  localparam int WIDE_W = LANES * (EXP_W + MAN_W + 1);
  localparam int RES_W  = LANES * INT_W;

  ctrlStrb_t        strb;
  logic             anyInv;
  logic [RES_W-1:0] dstReg;

  dcvt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .invMask(invMask),
    .anyInv(anyInv), .strb(strb), .outValid(outValid), .excOut(excRaise)
  );

  dcvt_dp #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .LANES(LANES)) uDp (
    .clk(clk), .rstN(rstN), .srcData(srcData), .strb(strb), .anyInv(anyInv),
    .dstReg(dstReg), .flagInv(flagInvalid), .flagPrec(flagPrecision)
  );

  assign narrowDst = dstReg;
  assign wideDst   = {{(WIDE_W-RES_W){1'b0}}, dstReg};

  AST_EXC_KEEPS_DST: assert property (@(posedge clk) disable iff (!rstN)
    excRaise |-> (narrowDst == $past(narrowDst))); // R8
endmodule

// File: tb/tb_dcvt_trunc2.sv
module tb_dcvt_trunc2;
  logic         clk = 1'b0, rstN = 1'b0, inValid = 1'b0, invMask = 1'b1;
  logic [127:0] srcData = '0;
  logic         outValid, excRaise, flagInvalid, flagPrecision;
  logic [127:0] wideDst;
  logic [63:0]  narrowDst;

  dcvt_trunc2 dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .invMask(invMask), .srcData(srcData),
    .outValid(outValid), .excRaise(excRaise), .flagInvalid(flagInvalid),
    .flagPrecision(flagPrecision), .wideDst(wideDst), .narrowDst(narrowDst)
  );

  always #2.5 clk = ~clk;

  int   checks = 0, fails = 0;
  bit   done = 1'b0;
  logic [63:0] expDst = '0;
  logic expInv = 1'b0, expPrec = 1'b0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Arithmetic reference for one lane.
  task automatic refLane(input logic [63:0] b, output logic [31:0] r, output logic inv, output logic pr);
    real x;
    int  t;
    x = $bitstoreal(b);
    if (b[62:52] == 11'h7FF || x >= 2147483648.0 || x <= -2147483649.0) begin
      r = 32'h8000_0000; inv = 1'b1; pr = 1'b0;
    end else begin
      t = $rtoi(x);
      r = t; inv = 1'b0; pr = ($itor(t) != x);
    end
  endtask

  task automatic doOp(input logic [63:0] a, input logic [63:0] b, input logic mask);
    logic [31:0] r0, r1;
    logic i0, i1, p0, p1, exc;
    refLane(a, r0, i0, p0);
    refLane(b, r1, i1, p1);
    exc     = (i0 | i1) & ~mask;
    expInv  = i0 | i1;
    expPrec = p0 | p1;
    if (!exc) expDst = {r1, r0};
    @(negedge clk);
    srcData = {b, a}; invMask = mask; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R9 outValid", {127'b0, outValid}, 128'd1);
    chk("R8 excRaise", {127'b0, excRaise}, {127'b0, exc});
    chk("R4 flagInvalid", {127'b0, flagInvalid}, {127'b0, expInv});
    chk("R5/R6/R7 flagPrecision", {127'b0, flagPrecision}, {127'b0, expPrec});
    chk("R1/R3/R4/R6/R7/R8 narrowDst", {64'b0, narrowDst}, {64'b0, expDst});
    chk("R2 wideDst", wideDst, {64'b0, expDst});
    @(negedge clk);
    // R9: idle cycle holds results and quiets the strobes
    chk("R9 idle", {61'b0, outValid, excRaise, flagInvalid, flagPrecision, narrowDst},
        {61'b0, 1'b0, 1'b0, expInv, expPrec, expDst});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [10:0] exps [40];
    logic [51:0] mans [8];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 reset", {wideDst[63:0], narrowDst}, 128'b0);
    chk("R10 reset flags", {124'b0, outValid, excRaise, flagInvalid, flagPrecision}, 128'b0);

    // Directed boundaries
    doOp($realtobits(2147483647.9), $realtobits(-7.75), 1'b1);            // R3
    doOp($realtobits(-2147483648.5), $realtobits(-2147483648.0), 1'b1);   // R6
    doOp($realtobits(-2147483649.0), $realtobits(2147483648.0), 1'b1);    // R4
    doOp(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b1);         // R7
    doOp(64'h0000_0000_0000_0000, $realtobits(-0.999), 1'b1);             // R7
    doOp(64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0001, 1'b1);         // R4 quiet/signalling NaN
    doOp(64'hFFF0_0000_0000_0000, $realtobits(3.5), 1'b1);                // R4/R5 inf + inexact
    doOp($realtobits(123.0), $realtobits(-456.0), 1'b0);                  // R1 exact
    doOp($realtobits(1.5), 64'h7FF0_0000_0000_0000, 1'b0);                // R8 unmasked
    doOp($realtobits(5e9), $realtobits(-2.25), 1'b0);                     // R8 unmasked

    // Sweep exponents around the int32 boundary
    exps[0] = 11'h000; exps[1] = 11'h001;
    for (int k = 0; k < 36; k++) exps[2+k] = 11'(11'h3FE + k);
    exps[38] = 11'h7FE; exps[39] = 11'h7FF;
    mans[0] = '0;            mans[1] = 52'd1;
    mans[2] = 52'h8_0000_0000_0000; mans[3] = '1;
    mans[4] = 52'h0_0000_0020_0000; mans[5] = 52'h0_0000_0010_0000;
    mans[6] = 52'h0_0000_001F_FFFF; mans[7] = 52'h5_5555_5555_5555;
    for (int ei = 0; ei < 40; ei++) begin
      for (int mi = 0; mi < 8; mi++) begin
        for (int s = 0; s < 2; s++) begin
          doOp({s[0], exps[ei], mans[mi]},
               {~s[0], exps[(ei + 5) % 40], mans[(mi + 3) % 8]},
               ((ei + mi) % 4) != 0);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule